// File: doc/BRIEF.md
# Pixel threshold keying and RGB16 packer

This block sits behind a colour-space converter and post-processes one 32-bit RGBA pixel per clock. Two programmable 8-bit thresholds key out dark pixels. A pixel whose red, green and blue are all below the first threshold becomes fully transparent black. A pixel whose channels are all below the second threshold keeps its colour but gets a fixed half-transparent alpha code. After keying, an optional bias inverts the top bit of each colour channel. An optional packer then reduces the pixel to 16 bits: five bits per colour and one alpha bit that marks half transparency.

Pixels enter and leave through a valid/ready stream with one register stage. A threshold-set command word can arrive at any time. It takes effect only on a macroblock boundary, so every pixel of a macroblock is keyed with the same pair of thresholds. A macroblock is `MB_PIXELS` accepted pixels, 256 by default. In 32-bit mode that fills 64 quadwords, and in 16-bit mode it fills 32. The bias and 16-bit mode inputs are sampled with each accepted pixel.

Pixel layout on both stream ports in 32-bit form: red in bits 7:0, green in 15:8, blue in 23:16, alpha in 31:24.

Top module: `pix_key_pack`

## Requirements
- R1: A threshold command word loads threshold A from bits 7:0 and threshold B from bits 23:16. All other command bits are ignored.
- R2: When red, green and blue are all strictly below threshold A (unsigned), the whole 32-bit pixel, alpha included, becomes zero.
- R3: Otherwise, when red, green and blue are all strictly below threshold B, alpha becomes 0x40 and the colours are unchanged. A channel equal to a threshold is not below it.
- R4: With threshold A zero and threshold B nonzero, only the half-transparency rule of R3 can act.
- R5: With both thresholds zero, a pixel passes through unchanged.
- R6: With bias set, the keyed pixel is XORed with 0x00808080: the top bit of each colour channel is inverted and alpha is untouched. A fully keyed pixel therefore leaves as 0x00808080.
- R7: In 16-bit mode, out_pix[4:0] is red>>3, [9:5] is green>>3, [14:10] is blue>>3, and [15] is 1 exactly when the keyed alpha equals 0x40. Bits 31:16 are zero.
- R8: An accepted pixel appears on the output one cycle later. in_ready is high whenever the output register is empty or being drained. A stalled output holds its value.
- R9: After reset, out_valid is low and both thresholds are zero.
- R10: A threshold command takes effect only once no macroblock is partly accepted. A write after some, but not all, of a macroblock's pixels leaves the rest of that macroblock keyed with the old thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_pix | input | 32 | Input RGBA pixel |
| thr_we | input | 1 | Threshold command strobe |
| thr_word | input | 32 | Threshold command word |
| mode_bias | input | 1 | Invert colour top bits for this pixel |
| mode_rgb16 | input | 1 | Pack this pixel to 16 bits |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_pix | output | 32 | Processed pixel (16-bit form in bits 15:0) |

## Verification
The hardest case to reach from the ports is a threshold write in the middle of a macroblock. The stream must be stopped after a partial count of pixels and the command issued there. The rest of that macroblock must then be shown to still pass through, and the next macroblock must show the new keying. Every stimulus vector sends a full macroblock so that the boundary counter stays aligned. The strict comparison is probed with a channel exactly equal to a threshold, and the ignored command bits are probed with nonzero values.

// File: rtl/pkp_pkg.sv
package pkp_pkg;
    localparam int CH_W       = 8;
    localparam int PIX_W      = 4 * CH_W;
    localparam int PK_CH_W    = 5;
    localparam int PK_W       = 3 * PK_CH_W + 1;
    localparam logic [CH_W-1:0] ALPHA_HALF = 8'h40;

    typedef logic [CH_W-1:0] chan_t;

    typedef struct packed {
        chan_t a;
        chan_t b;
        chan_t g;
        chan_t r;
    } rgba_t;

    typedef struct packed {
        chan_t t_half;
        chan_t t_clear;
    } thresh_t;

    typedef enum logic [1:0] {
        KEY_PASS  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_CLEAR = 2'd2
    } key_e;

    function automatic logic all_below(rgba_t p, chan_t t);
        return (p.r < t) && (p.g < t) && (p.b < t);
    endfunction

    function automatic thresh_t decode_thresh(logic [PIX_W-1:0] w);
        thresh_t t;
        t.t_clear = w[CH_W-1:0];
        t.t_half  = w[2*CH_W +: CH_W];
        return t;
    endfunction

    function automatic logic [PIX_W-1:0] pack16(rgba_t p);
        logic [PIX_W-1:0] o;
        o = '0;
        o[0*PK_CH_W +: PK_CH_W] = p.r[CH_W-1 -: PK_CH_W];
        o[1*PK_CH_W +: PK_CH_W] = p.g[CH_W-1 -: PK_CH_W];
        o[2*PK_CH_W +: PK_CH_W] = p.b[CH_W-1 -: PK_CH_W];
        o[PK_W-1]               = (p.a == ALPHA_HALF);
        return o;
    endfunction
endpackage

// File: rtl/pkp_thresh.sv
module pkp_thresh
    import pkp_pkg::*;
#(
    parameter int MB_PIXELS = 256,
    parameter int CNT_W     = $clog2(MB_PIXELS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic [PIX_W-1:0] cmd_word,
    input  logic             px_take,
    output thresh_t          thr_act,
    output logic [CNT_W-1:0] mb_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MB_PIXELS - 1);

    thresh_t thr_shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_shadow <= '0;
        end else if (cmd_we) begin
            thr_shadow <= decode_thresh(cmd_word);
        end
    end

    // Active pair reloads only while no macroblock is partly accepted.
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_act <= '0;
        end else if (mb_cnt == '0) begin
            thr_act <= thr_shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mb_cnt <= '0;
        end else if (px_take) begin
            mb_cnt <= (mb_cnt == LAST) ? '0 : mb_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pkp_key.sv
module pkp_key
    import pkp_pkg::*;
(
    input  rgba_t            px_in,
    input  thresh_t          thr,
    input  logic             bias,
    input  logic             rgb16,
    output logic [PIX_W-1:0] px_out
);
    localparam logic [PIX_W-1:0] BIAS_MASK = {{CH_W{1'b0}}, {3{1'b1, {(CH_W-1){1'b0}}}}};

    key_e  kind;
    rgba_t keyed;
    rgba_t biased;

    always_comb begin
        if (all_below(px_in, thr.t_clear)) begin
            kind = KEY_CLEAR;
        end else if (all_below(px_in, thr.t_half)) begin
            kind = KEY_HALF;
        end else begin
            kind = KEY_PASS;
        end
    end

    always_comb begin
        keyed = px_in;
        case (kind)
            KEY_CLEAR: keyed = '0;
            KEY_HALF:  keyed.a = ALPHA_HALF;
            default:   keyed = px_in;
        endcase
    end

    always_comb begin
        biased = bias ? rgba_t'(keyed ^ BIAS_MASK) : keyed;
        px_out = rgb16 ? pack16(biased) : PIX_W'(biased);
    end
endmodule

// File: rtl/pix_key_pack.sv
module pix_key_pack
    import pkp_pkg::*;
#(
    parameter int MB_PIXELS = 256,
    localparam int CNT_W    = $clog2(MB_PIXELS)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_pix,
    input  logic        thr_we,
    input  logic [31:0] thr_word,
    input  logic        mode_bias,
    input  logic        mode_rgb16,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_pix
);
    thresh_t          thr_act;
    logic [CNT_W-1:0] mb_cnt;
    logic [PIX_W-1:0] px_next;
    logic             take;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    pkp_thresh #(.MB_PIXELS(MB_PIXELS), .CNT_W(CNT_W)) u_thresh (
        .clk      (clk),
        .rst      (rst),
        .cmd_we   (thr_we),
        .cmd_word (thr_word),
        .px_take  (take),
        .thr_act  (thr_act),
        .mb_cnt   (mb_cnt)
    );

    pkp_key u_key (
        .px_in  (rgba_t'(in_pix)),
        .thr    (thr_act),
        .bias   (mode_bias),
        .rgb16  (mode_rgb16),
        .px_out (px_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_pix <= px_next;
            end
        end
    end
endmodule

// File: rtl/pkp_checker.sv
module pkp_checker
    import pkp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             mode_rgb16,
    input logic             out_valid,
    input logic             out_ready,
    input logic [31:0]      out_pix,
    input logic [CNT_W-1:0] mb_cnt,
    input thresh_t          thr_act
);
    p_ready_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    p_pack_hi_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && mode_rgb16) |=> (out_pix[31:16] == 16'h0));

    p_thr_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (mb_cnt != '0) |=> $stable(thr_act));

    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!out_valid && thr_act == '0));
endmodule

bind pix_key_pack pkp_checker #(.CNT_W(CNT_W)) u_pkp_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .mode_rgb16 (mode_rgb16),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_pix    (out_pix),
    .mb_cnt     (mb_cnt),
    .thr_act    (thr_act)
);

// File: tb/test_pix_key_pack.sv
module test_pix_key_pack;
    localparam int MB = 256;
    localparam int NV = 14;

    // {thr_word, bias, rgb16, pixel in, expected out}
    localparam logic [97:0] VEC [NV] = '{
        {32'h0000_0000, 1'b0, 1'b0, 32'h7F10_2030, 32'h7F10_2030},
        {32'h0080_0020, 1'b0, 1'b0, 32'hFF05_1F10, 32'h0000_0000},
        {32'h0080_0020, 1'b0, 1'b0, 32'hFF10_1020, 32'h4010_1020},
        {32'h0080_0020, 1'b0, 1'b0, 32'h1200_807F, 32'h1200_807F},
        {32'h0050_0000, 1'b0, 1'b0, 32'h9901_0203, 32'h4001_0203},
        {32'hFF3C_AA05, 1'b0, 1'b0, 32'h7704_0404, 32'h0000_0000},
        {32'hFF3C_AA05, 1'b0, 1'b0, 32'h7705_0404, 32'h4005_0404},
        {32'h0000_0000, 1'b1, 1'b0, 32'h1122_3344, 32'h11A2_B3C4},
        {32'h0000_0020, 1'b1, 1'b0, 32'hFF01_0101, 32'h0080_8080},
        {32'h0000_0000, 1'b0, 1'b1, 32'h4017_08FF, 32'h0000_883F},
        {32'h0000_0000, 1'b0, 1'b1, 32'h4180_F807, 32'h0000_43E0},
        {32'h0030_0000, 1'b0, 1'b1, 32'hFF28_2828, 32'h0000_94A5},
        {32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_4210},
        {32'h0000_0010, 1'b0, 1'b1, 32'h400F_0F0F, 32'h0000_0000}
    };

    function automatic string vec_tag(int i);
        case (i)
            0:       return "R5 passthrough";
            1:       return "R2 full clear";
            2:       return "R3 equal to threshold A";
            3:       return "R3 channel equal to threshold B";
            4:       return "R4 half only";
            5, 6:    return "R1 command field decode";
            7, 8:    return "R6 bias";
            9, 10:   return "R7 pack16";
            11:      return "R7 pack16 half alpha";
            12:      return "R6 bias then pack";
            default: return "R2 clear then pack";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_pix = '0;
    logic        thr_we = 1'b0;
    logic [31:0] thr_word = '0;
    logic        mode_bias = 1'b0;
    logic        mode_rgb16 = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_pix;

    int          nchk = 0;
    int          nfail = 0;
    bit          done = 1'b0;
    bit          mon_on = 1'b0;
    logic [31:0] cur_exp = '0;
    int          nout = 0;
    int          nbad = 0;
    logic [31:0] first_bad = '0;

    always #5 clk = ~clk;

    pix_key_pack i_pix_key_pack (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_pix     (in_pix),
        .thr_we     (thr_we),
        .thr_word   (thr_word),
        .mode_bias  (mode_bias),
        .mode_rgb16 (mode_rgb16),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_pix    (out_pix)
    );

    always @(negedge clk) begin
        if (mon_on && out_valid && out_ready) begin
            nout++;
            if (out_pix !== cur_exp) begin
                if (nbad == 0) first_bad = out_pix;
                nbad++;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(logic [31:0] p);
        in_valid = 1'b1;
        in_pix   = p;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic write_thr(logic [31:0] w);
        thr_we   = 1'b1;
        thr_word = w;
        @(negedge clk);
        thr_we   = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic start_mon(logic [31:0] e);
        cur_exp = e;
        nout    = 0;
        nbad    = 0;
        mon_on  = 1'b1;
    endtask

    task automatic end_mon(string tag);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        mon_on = 1'b0;
        chk(tag, (nbad != 0) ? first_bad : cur_exp, cur_exp);
        chk(tag, 32'(nout), 32'(MB));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state at the ports
        chk("R9 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R9 in_ready after reset", 32'(in_ready), 32'd1);
        // R9: thresholds zero, so a dark pixel passes unchanged
        start_mon(32'h0101_0101);
        for (int k = 0; k < MB; k++) push(32'h0101_0101);
        end_mon("R9 reset thresholds zero");

        for (int v = 0; v < NV; v++) begin
            write_thr(VEC[v][97:66]);
            mode_bias  = VEC[v][65];
            mode_rgb16 = VEC[v][64];
            start_mon(VEC[v][31:0]);
            for (int k = 0; k < MB; k++) push(VEC[v][63:32]);
            end_mon(vec_tag(v));
        end
        mode_bias  = 1'b0;
        mode_rgb16 = 1'b0;

        // R10: write in mid macroblock is deferred to the next boundary
        write_thr(32'h0000_0000);
        start_mon(32'h8010_1010);
        for (int k = 0; k < 10; k++) push(32'h8010_1010);
        in_valid = 1'b0;
        write_thr(32'h0000_0020);
        for (int k = 10; k < MB; k++) push(32'h8010_1010);
        end_mon("R10 old thresholds kept in macroblock");
        repeat (2) @(negedge clk);
        start_mon(32'h0000_0000);
        for (int k = 0; k < MB; k++) push(32'h8010_1010);
        end_mon("R10 new thresholds at boundary");

        // R8: stall holds the output, blocks input, then resumes
        write_thr(32'h0000_0000);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_pix    = 32'h0102_0304;
        @(negedge clk);
        in_pix = 32'h0506_0708;
        chk("R8 latency one", 32'(out_valid), 32'd1);
        for (int k = 0; k < 3; k++) begin
            chk("R8 stalled output held", out_pix, 32'h0102_0304);
            chk("R8 input blocked while stalled", 32'(in_ready), 32'd0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 next pixel after release", out_pix, 32'h0506_0708);
        @(negedge clk);
        chk("R8 drained", 32'(out_valid), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule